// File: doc/BRIEF.md
# Per-Set Live Value Counter

This block keeps, for every accumulation set in a streaming reduction unit, the number of partial values of that set that are still alive. An alive value is one that sits in an input queue, in a holding register, or in the adder pipeline. The surrounding scheduler reports three kinds of event. An arrival adds one value. An adder issue takes two values of a set and produces one, so it removes one. An ejection of the final result removes the last one. The scheduler also presents the set index currently leaving the adder as a query. One cycle later the block returns the live count for that index and a flag that is high when the count is exactly one, which means the set is fully reduced and may be ejected.

The count is held across three counter tables, one per event type. Each table has its own read-modify-write port, so no table ever sees two writes in one cycle. The tables are filled with zero at power-up and are never cleared at run time. A set is complete when the three read values sum to exactly one. Ejection brings an index back to a net zero, so the same index can be handed to a later set without any clearing.

The caller passes the low bits of the set ID as the index. Sets whose IDs differ only in the upper bits share one entry, so the number of sets alive at once must stay below the table depth.

Top module: `set_count_tracker`

## Requirements
- R1: An arrival (`arr_valid`=1) adds one to the count of index `arr_idx`.
- R2: An adder issue (`iss_valid`=1) subtracts one from the count of index `iss_idx`.
- R3: An ejection (`ej_valid`=1) subtracts one from the count of index `ej_idx`.
- R4: `done` is 1 in the cycle after a cycle with `q_valid`=1 exactly when the count of `q_idx` is one. It is 0 after any cycle with `q_valid`=0, and 0 while `rst_n` is low.
- R5: `active_cnt` is the count of the queried index as a CNT_W-bit (default 16) two's-complement value, equal to arrivals minus issues minus ejections modulo 2^CNT_W, so more removals than arrivals reads as a negative number, e.g. 16'hFFFF for minus one.
- R6: The result for a query presented in cycle c includes every event presented up to cycle c-1. It excludes events presented in cycle c itself.
- R7: Events on the same index in consecutive cycles, of the same or of different kinds, are all counted.
- R8: An index whose count has returned to zero can be reused by a new set, and the new set's count starts from zero.
- R9: A runtime reset leaves every count intact, provided no event was presented in the cycle just before reset asserts.
- R10: Arrival, issue and ejection may name the same index in one cycle; the net change of +1-1-1 is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | 1 | A value of a set arrives |
| arr_idx | input | IDX_W | Table index of the arriving set |
| iss_valid | input | 1 | Two values of a set enter the adder |
| iss_idx | input | IDX_W | Table index of the set entering the adder |
| ej_valid | input | 1 | Final result of a set leaves the unit |
| ej_idx | input | IDX_W | Table index of the ejected set |
| q_valid | input | 1 | Query request |
| q_idx | input | IDX_W | Table index at the adder output |
| active_cnt | output | CNT_W | Live count of the queried index |
| done | output | 1 | Queried set is reduced to one value |

## Verification
Two kinds of activity can fall in the same cycle and on the same index: an event being counted, and a query or a second event reading that entry. The first case puts a query in the same cycle as an event on its index. The second puts two events on one index in back-to-back cycles, and also puts all three event kinds on one index in a single cycle. A behavioural reference built from integer counts is applied at each clock edge, and the design's count and flag are compared against it every cycle. Timing errors show up as an off-by-one count on a held query.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int unsigned SCT_IDX_W = 8;
  localparam int unsigned SCT_CNT_W = 16;
  localparam int unsigned SCT_NBANK = 3;
  // bank order: 0 arrivals (count up), 1 adder issues, 2 ejections (count down)
  typedef enum logic [1:0] {
    BANK_ARRIVE = 2'd0,
    BANK_ISSUE  = 2'd1,
    BANK_EJECT  = 2'd2
  } bank_id_e;
endpackage

// File: rtl/sct_cnt_bank.sv
module sct_cnt_bank #(
  parameter int unsigned IDX_W = sct_pkg::SCT_IDX_W,
  parameter int unsigned CNT_W = sct_pkg::SCT_CNT_W,
  parameter bit          DEC   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [CNT_W-1:0] mem [DEPTH];

  // power-up content of the table; the runtime reset never touches it
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  logic             pend_v;
  logic [IDX_W-1:0] pend_idx;
  logic [CNT_W-1:0] pend_base;
  logic [CNT_W-1:0] wr_data;
  logic [CNT_W-1:0] base_nxt;
  logic [CNT_W-1:0] rd_nxt;

  // write value of the event captured last cycle
  always_comb begin
    if (DEC) wr_data = pend_base - CNT_W'(1);
    else     wr_data = pend_base + CNT_W'(1);
  end

  // forward the write landing this edge to a new event or to the query
  always_comb begin
    if (pend_v && (pend_idx == ev_idx)) base_nxt = wr_data;
    else                                base_nxt = mem[ev_idx];
    if (pend_v && (pend_idx == rd_idx)) rd_nxt = wr_data;
    else                                rd_nxt = mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_v <= 1'b0;
    else        pend_v <= ev_valid;
  end

  always_ff @(posedge clk) begin
    if (ev_valid) begin
      pend_idx  <= ev_idx;
      pend_base <= base_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_v) mem[pend_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= rd_nxt;
  end
endmodule

// File: rtl/sct_sum.sv
module sct_sum #(
  parameter int unsigned CNT_W = sct_pkg::SCT_CNT_W,
  parameter int unsigned NBANK = sct_pkg::SCT_NBANK
) (
  input  logic [NBANK-1:0][CNT_W-1:0] part,
  input  logic                        q_seen,
  output logic [CNT_W-1:0]            total,
  output logic                        single
);
  always_comb begin
    total = '0;
    for (int b = 0; b < NBANK; b++) total = total + part[b];
  end

  assign single = q_seen && (total == CNT_W'(1));
endmodule

// File: rtl/set_count_tracker.sv
module set_count_tracker #(
  parameter int unsigned IDX_W = sct_pkg::SCT_IDX_W,
  parameter int unsigned CNT_W = sct_pkg::SCT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arr_valid,
  input  logic [IDX_W-1:0] arr_idx,
  input  logic             iss_valid,
  input  logic [IDX_W-1:0] iss_idx,
  input  logic             ej_valid,
  input  logic [IDX_W-1:0] ej_idx,
  input  logic             q_valid,
  input  logic [IDX_W-1:0] q_idx,
  output logic [CNT_W-1:0] active_cnt,
  output logic             done
);
  import sct_pkg::*;
  localparam int unsigned NBANK = SCT_NBANK;

  logic [NBANK-1:0]              ev_v;
  logic [NBANK-1:0][IDX_W-1:0]   ev_i;
  logic [NBANK-1:0][CNT_W-1:0]   part;
  logic                          q_seen;

  always_comb begin
    ev_v[BANK_ARRIVE] = arr_valid;
    ev_i[BANK_ARRIVE] = arr_idx;
    ev_v[BANK_ISSUE]  = iss_valid;
    ev_i[BANK_ISSUE]  = iss_idx;
    ev_v[BANK_EJECT]  = ej_valid;
    ev_i[BANK_EJECT]  = ej_idx;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sct_cnt_bank #(
      .IDX_W (IDX_W),
      .CNT_W (CNT_W),
      .DEC   (g != int'(BANK_ARRIVE))
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_valid (ev_v[g]),
      .ev_idx   (ev_i[g]),
      .rd_idx   (q_idx),
      .rd_data  (part[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_seen <= 1'b0;
    else        q_seen <= q_valid;
  end

  sct_sum #(
    .CNT_W (CNT_W),
    .NBANK (NBANK)
  ) u_sum (
    .part   (part),
    .q_seen (q_seen),
    .total  (active_cnt),
    .single (done)
  );
endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arr_valid,
  input logic [IDX_W-1:0] arr_idx,
  input logic             iss_valid,
  input logic [IDX_W-1:0] iss_idx,
  input logic             ej_valid,
  input logic [IDX_W-1:0] ej_idx,
  input logic             q_valid,
  input logic [IDX_W-1:0] q_idx,
  input logic [CNT_W-1:0] active_cnt,
  input logic             done
);
  // previous-cycle query and events, reset so nothing is armed at start
  logic             pq_v, pa_v, pi_v, pe_v, arm;
  logic [IDX_W-1:0] pq_i, pa_i, pi_i, pe_i;
  logic [CNT_W-1:0] prev_cnt, exp_delta, delta_now;

  always_comb begin
    delta_now = '0;
    if (pa_v && pa_i == q_idx) delta_now = delta_now + CNT_W'(1);
    if (pi_v && pi_i == q_idx) delta_now = delta_now - CNT_W'(1);
    if (pe_v && pe_i == q_idx) delta_now = delta_now - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq_v <= 1'b0; pa_v <= 1'b0; pi_v <= 1'b0; pe_v <= 1'b0; arm <= 1'b0;
      pq_i <= '0; pa_i <= '0; pi_i <= '0; pe_i <= '0;
      prev_cnt <= '0; exp_delta <= '0;
    end else begin
      pq_v <= q_valid;   pq_i <= q_idx;
      pa_v <= arr_valid; pa_i <= arr_idx;
      pi_v <= iss_valid; pi_i <= iss_idx;
      pe_v <= ej_valid;  pe_i <= ej_idx;
      arm       <= q_valid && pq_v && (q_idx == pq_i);
      prev_cnt  <= active_cnt;
      exp_delta <= delta_now;
    end
  end

  // R4: the flag only ever reports a count of exactly one
  a_r4_done_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (active_cnt == CNT_W'(1)));

  // R4: no query, no flag
  a_r4_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !done);

  // R4: a queried count of one raises the flag
  a_r4_one_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> ((active_cnt == CNT_W'(1)) == done));

  // R1 R2 R3 R6 R7: a held query moves by exactly the previous cycle's events
  a_r7_held_query_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (active_cnt == CNT_W'(prev_cnt + exp_delta)));
endmodule

bind set_count_tracker sct_checker #(
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) u_sct_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arr_valid  (arr_valid),
  .arr_idx    (arr_idx),
  .iss_valid  (iss_valid),
  .iss_idx    (iss_idx),
  .ej_valid   (ej_valid),
  .ej_idx     (ej_idx),
  .q_valid    (q_valid),
  .q_idx      (q_idx),
  .active_cnt (active_cnt),
  .done       (done)
);

// File: tb/set_count_tracker_tb_top.sv
module set_count_tracker_tb_top;
  localparam int IDX_W  = 8;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int PERIOD = 10;

  logic clk, rst_n;
  logic arr_valid, iss_valid, ej_valid, q_valid;
  logic [IDX_W-1:0] arr_idx, iss_idx, ej_idx, q_idx;
  logic [CNT_W-1:0] active_cnt;
  logic done;

  set_count_tracker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .arr_valid(arr_valid), .arr_idx(arr_idx),
    .iss_valid(iss_valid), .iss_idx(iss_idx),
    .ej_valid(ej_valid), .ej_idx(ej_idx),
    .q_valid(q_valid), .q_idx(q_idx),
    .active_cnt(active_cnt), .done(done)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R4";
  bit    check_en = 0;

  // reference: one integer count per index, events applied at the edge
  int           model [DEPTH];
  bit           exp_qv = 0;
  logic [CNT_W-1:0] exp_cnt = '0;

  initial begin
    clk = 0;
    forever #(PERIOD/2) clk = ~clk;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_qv = 0;
    end else begin
      exp_qv  = q_valid;
      exp_cnt = CNT_W'(model[q_idx]);
      if (arr_valid) model[arr_idx] = model[arr_idx] + 1;
      if (iss_valid) model[iss_idx] = model[iss_idx] - 1;
      if (ej_valid)  model[ej_idx]  = model[ej_idx] - 1;
    end
  end

  always @(negedge clk) begin
    if (check_en) begin
      bit exp_done;
      exp_done = exp_qv && (exp_cnt == CNT_W'(1));
      vectors++;
      if (done !== exp_done) begin
        miscompares++;
        $display("FAIL %s done: actual %b expected %b at %0t", cur_req, done, exp_done, $time);
      end
      if (exp_qv) begin
        vectors++;
        if (active_cnt !== exp_cnt) begin
          miscompares++;
          $display("FAIL %s active_cnt: actual %h expected %h at %0t", cur_req, active_cnt, exp_cnt, $time);
        end
      end
    end
  end

  task automatic step(input bit av, input int ai, input bit iv, input int ii,
                      input bit ev, input int ei, input bit qv, input int qi);
    arr_valid = av; arr_idx = IDX_W'(ai);
    iss_valid = iv; iss_idx = IDX_W'(ii);
    ej_valid  = ev; ej_idx  = IDX_W'(ei);
    q_valid   = qv; q_idx   = IDX_W'(qi);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n, input int qi);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 1, qi);
  endtask

  initial begin
    #(PERIOD*100000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
    rst_n = 0;
    arr_valid = 0; iss_valid = 0; ej_valid = 0; q_valid = 0;
    arr_idx = '0; iss_idx = '0; ej_idx = '0; q_idx = '0;
    #2 check_en = 1;
    cur_req = "R4";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, 5);
    step(0, 0, 0, 0, 0, 0, 0, 5);

    cur_req = "R1";
    for (int k = 0; k < 3; k++) step(1, 5, 0, 0, 0, 0, 0, 0);
    idle(3, 5);

    cur_req = "R2";
    step(0, 0, 1, 5, 0, 0, 1, 5);
    step(0, 0, 1, 5, 0, 0, 1, 5);
    idle(3, 5);

    cur_req = "R3";
    step(0, 0, 0, 0, 1, 5, 1, 5);
    idle(3, 5);

    cur_req = "R6";
    for (int k = 0; k < 4; k++) step(1, 9, 0, 0, 0, 0, 1, 9);
    step(0, 0, 1, 9, 0, 0, 1, 9);
    idle(3, 9);

    cur_req = "R7";
    step(1, 12, 0, 0, 0, 0, 1, 12);
    step(1, 12, 1, 12, 0, 0, 1, 12);
    step(0, 0, 1, 12, 0, 0, 1, 12);
    step(1, 12, 0, 0, 0, 0, 1, 12);
    step(0, 0, 1, 12, 0, 0, 1, 12);
    step(0, 0, 0, 0, 1, 12, 1, 12);
    idle(3, 12);

    cur_req = "R5";
    step(0, 0, 1, 200, 0, 0, 1, 200);
    step(0, 0, 0, 0, 1, 200, 1, 200);
    idle(3, 200);

    cur_req = "R8";
    for (int k = 0; k < 3; k++) step(1, 7, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 7, 0, 0, 0, 0);
    step(0, 0, 1, 7, 0, 0, 1, 7);
    step(0, 0, 0, 0, 1, 7, 1, 7);
    idle(2, 7);
    step(1, 7, 0, 0, 0, 0, 1, 7);
    idle(3, 7);

    cur_req = "R10";
    step(1, 30, 0, 0, 0, 0, 1, 30);
    step(1, 30, 0, 0, 0, 0, 1, 30);
    step(1, 30, 1, 30, 1, 30, 1, 30);
    step(1, 31, 1, 30, 1, 32, 1, 30);
    idle(3, 30);
    idle(2, 31);

    cur_req = "R9";
    idle(2, 9);
    rst_n = 0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
    idle(3, 9);
    idle(3, 12);

    cur_req = "R7";
    for (int k = 0; k < 600; k++) begin
      int a, b, c, q;
      a = $urandom_range(0, 3); b = $urandom_range(0, 3);
      c = $urandom_range(0, 3); q = $urandom_range(0, 3);
      step($urandom_range(0, 1) == 1, 40 + a, $urandom_range(0, 1) == 1, 40 + b,
           $urandom_range(0, 3) == 0, 40 + c, $urandom_range(0, 3) != 0, 40 + q);
    end
    idle(3, 41);

    check_en = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule